// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration bitstream into a target programmable device over a two-wire passive serial link: one data line and one configuration clock line. A single start pulse switches on the target's power, holds its active-low configure line low for a fixed reset interval and then releases it. After that the block takes payload bytes from an upstream valid/ready stream and shifts each byte out one bit per configuration clock.

When the byte flagged as last has been shifted out, the block issues a fixed run of extra clocks with the data line held at zero. It then reads the target's two status inputs, config-done and status. It ends the load by raising either a done flag or an error flag. Both flags stay set until the next accepted start. While a load is running, the busy output is high and further start pulses are ignored.

The configuration clock is derived from the system clock by a half-period count. Data changes only when the configuration clock falls, so it is stable at every rising edge.

Top module: `psc_loader`

## Requirements
- R1: After reset, busy_o, done_o, err_o, dclk_o, dat_o and in_ready_o are 0. cfg_n_o is 1, and pwrdn_o is 1, which means the target is powered off.
- R2: An accepted start drives pwrdn_o to 0 (power on) on the next clock edge. pwrdn_o stays 0 for the rest of the load and afterwards.
- R3: An accepted start holds cfg_n_o at 0 for exactly RST_CYC system clock cycles. dclk_o stays 0 for that whole time.
- R4: Each payload byte is sent as DATA_W bits, least significant bit first, with one rising edge of dclk_o per bit. Each high and each low phase of dclk_o lasts HALF cycles. dat_o does not change while dclk_o is high.
- R5: in_ready_o is 1 only while the block is waiting for the next byte: cfg_n_o is 1 and dclk_o is 0. Each handshake, meaning in_valid_i and in_ready_o both 1 at a rising clock edge, takes exactly one byte. A 1 on in_last_i during a handshake marks that byte as the final one.
- R6: After the final byte, exactly TAIL further rising edges of dclk_o occur, all with dat_o equal to 0.
- R7: After the trailing clocks, if conf_done_i and status_i both read 1, done_o is set and err_o stays 0.
- R8: If any other combination of conf_done_i and status_i is read (00, 01 or 10), err_o is set and done_o stays 0.
- R9: A start pulse that arrives while busy_o is 1 has no effect. cfg_n_o does not fall again, and the bit stream continues unchanged.
- R10: busy_o falls when the load ends. At that point exactly one of done_o and err_o is 1. It stays 1 until the next accepted start clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| in_valid_i | input | 1 | Upstream byte valid |
| in_data_i | input | DATA_W | Upstream payload byte |
| in_last_i | input | 1 | Marks the final payload byte |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| conf_done_i | input | 1 | Target config-done status (asynchronous) |
| status_i | input | 1 | Target status line (asynchronous, 1 = good) |
| pwrdn_o | output | 1 | Active-low power-down line to the target |
| cfg_n_o | output | 1 | Active-low configure line to the target |
| dclk_o | output | 1 | Configuration clock |
| dat_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Sticky success flag |
| err_o | output | 1 | Sticky failure flag |

## Verification
The bench loads several byte patterns, each chosen to reveal a specific fault:
- 0x01 and 0x80 show whether the shift order is reversed.
- 0xA5 and 0x5A catch a bit that is dropped or repeated.
- 0x00 and 0xFF hide the trailing-zero run unless the edges are counted.
- A load of a single byte exercises the path where the first byte is also the final one.

Each status combination 11, 01, 10 and 00 is applied at the end of a load, to separate the success outcome from the three failure outcomes. One load also receives a start pulse while it is running. Re-triggering would show up as a second falling edge on the configure line or as a corrupted bit sequence.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_FETCH,
    ST_LO,
    ST_HI,
    ST_CHK
  } psc_state_e;

  // both status inputs must be high for a good load
  function automatic logic status_ok(input logic cd, input logic st);
    return cd & st;
  endfunction

  // larger of two counts, used to size shared counters
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/psc_timer.sv
module psc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/psc_loader.sv
module psc_loader
  import psc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RST_CYC = 25000,
  parameter int HALF    = 4,
  parameter int TAIL    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic              conf_done_i,
  input  logic              status_i,
  output logic              pwrdn_o,
  output logic              cfg_n_o,
  output logic              dclk_o,
  output logic              dat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int TW = $clog2(max2(RST_CYC, HALF) + 1);
  localparam int CW = $clog2(max2(TAIL, DATA_W) + 1);
  localparam logic [TW-1:0] RST_LOAD  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] HALF_LOAD = TW'(HALF - 1);
  localparam logic [CW-1:0] BYTE_BITS = CW'(DATA_W - 1);
  localparam logic [CW-1:0] TAIL_BITS = CW'(TAIL - 1);

  psc_state_e        st_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CW-1:0]     bits_q;
  logic              last_q, tail_q;
  logic              cfg_n_q, dclk_q, dat_q, pwrdn_q, done_q, err_q;

  // named internal events
  logic       start_acc, byte_acc, tmr_zero, lo_end, hi_end;
  logic       more_bits, enter_tail, load_end;
  logic       tmr_load;
  logic [TW-1:0] tmr_val;
  logic [1:0] stat_s;

  assign start_acc  = (st_q == ST_IDLE) && start_i;
  assign byte_acc   = (st_q == ST_FETCH) && in_valid_i;
  assign lo_end     = (st_q == ST_LO) && tmr_zero;
  assign hi_end     = (st_q == ST_HI) && tmr_zero;
  assign more_bits  = hi_end && (bits_q != '0);
  assign enter_tail = hi_end && (bits_q == '0) && !tail_q && last_q;
  assign load_end   = (st_q == ST_CHK);

  assign tmr_load = start_acc || byte_acc || lo_end || hi_end;
  assign tmr_val  = (st_q == ST_IDLE) ? RST_LOAD : HALF_LOAD;

  psc_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  psc_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({conf_done_i, status_i}),
    .q_o   (stat_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      shreg_q <= '0;
      bits_q  <= '0;
      last_q  <= 1'b0;
      tail_q  <= 1'b0;
      cfg_n_q <= 1'b1;
      dclk_q  <= 1'b0;
      dat_q   <= 1'b0;
      pwrdn_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          pwrdn_q <= 1'b0;
          cfg_n_q <= 1'b0;
          tail_q  <= 1'b0;
          st_q    <= ST_RST;
        end
        ST_RST: if (tmr_zero) begin
          cfg_n_q <= 1'b1;
          st_q    <= ST_FETCH;
        end
        ST_FETCH: if (in_valid_i) begin
          shreg_q <= in_data_i;
          last_q  <= in_last_i;
          bits_q  <= BYTE_BITS;
          dat_q   <= in_data_i[0];
          st_q    <= ST_LO;
        end
        ST_LO: if (tmr_zero) begin
          dclk_q <= 1'b1;
          st_q   <= ST_HI;
        end
        ST_HI: if (tmr_zero) begin
          dclk_q <= 1'b0;
          if (bits_q != '0) begin
            bits_q <= bits_q - 1'b1;
            if (!tail_q) begin
              shreg_q <= shreg_q >> 1;
              dat_q   <= shreg_q[1];
            end
            st_q <= ST_LO;
          end else if (tail_q) begin
            st_q <= ST_CHK;
          end else if (last_q) begin
            tail_q <= 1'b1;
            dat_q  <= 1'b0;
            bits_q <= TAIL_BITS;
            st_q   <= ST_LO;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_CHK: begin
          if (status_ok(stat_s[1], stat_s[0])) done_q <= 1'b1;
          else                                 err_q  <= 1'b1;
          tail_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o = (st_q == ST_FETCH);
  assign busy_o     = (st_q != ST_IDLE);
  assign pwrdn_o    = pwrdn_q;
  assign cfg_n_o    = cfg_n_q;
  assign dclk_o     = dclk_q;
  assign dat_o      = dat_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/psc_loader_chk.sv
module psc_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start_acc,
  input logic in_ready_o,
  input logic pwrdn_o,
  input logic cfg_n_o,
  input logic dclk_o,
  input logic dat_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  // R2: target powered while a load runs
  a_r2_power_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pwrdn_o);

  // R3: no configuration clock during the configure pulse
  a_r3_no_clk_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n_o |-> !dclk_o);

  // R4: data held while the configuration clock is high
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(dat_o));

  // R5: bytes are taken only between bit phases, outside the configure pulse
  a_r5_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (cfg_n_o && !dclk_o));

  // R7, R8: the two outcomes exclude each other
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R9: once released, the configure line stays high for the rest of the load
  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cfg_n_o) |=> cfg_n_o);

  // R10: end of load leaves exactly one outcome flag
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $onehot({done_o, err_o}));

  // R10: flags cleared by an accepted start
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!done_o && !err_o));

endmodule

bind psc_loader psc_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_acc  (start_acc),
  .in_ready_o (in_ready_o),
  .pwrdn_o    (pwrdn_o),
  .cfg_n_o    (cfg_n_o),
  .dclk_o     (dclk_o),
  .dat_o      (dat_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/psc_loader_tb_top.sv
`timescale 1ns/1ps
module psc_loader_tb_top;

  localparam int DATA_W  = 8;
  localparam int RST_CYC = 20;
  localparam int HALF    = 2;
  localparam int TAIL    = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic in_last_i = 1'b0;
  logic conf_done_i = 1'b0;
  logic status_i = 1'b0;
  logic in_ready_o, pwrdn_o, cfg_n_o, dclk_o, dat_o, busy_o, done_o, err_o;

  always #4 clk = ~clk;

  psc_loader #(.DATA_W(DATA_W), .RST_CYC(RST_CYC), .HALF(HALF), .TAIL(TAIL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .conf_done_i(conf_done_i), .status_i(status_i),
    .pwrdn_o(pwrdn_o), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o), .dat_o(dat_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural observer, sampled on every falling system clock edge
  bit   obs_bits[$];
  int   low_cfg_cycles = 0;
  int   cfg_falls = 0;
  int   phase_errs = 0;
  int   hi_len = 0, lo_len = 0;
  bit   prev_dclk = 1'b0, prev_cfg = 1'b1, prev_dat = 1'b0, seen_edge = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_n_o) low_cfg_cycles++;
      if (prev_cfg && !cfg_n_o) cfg_falls++;
      if (!cfg_n_o && dclk_o) phase_errs++;
      if (in_ready_o && (!cfg_n_o || dclk_o)) phase_errs++;
      if (dclk_o && !prev_dclk) begin
        obs_bits.push_back(dat_o);
        if (seen_edge && lo_len < HALF) phase_errs++;
        seen_edge = 1'b1;
        hi_len = 0;
      end
      if (dclk_o && prev_dclk && dat_o != prev_dat) phase_errs++;
      if (dclk_o) hi_len++;
      if (!dclk_o && prev_dclk) begin
        if (hi_len != HALF) phase_errs++;
        lo_len = 0;
      end
      if (!dclk_o) lo_len++;
      prev_dclk = dclk_o;
      prev_cfg  = cfg_n_o;
      prev_dat  = dat_o;
    end
  end

  task automatic clear_obs();
    obs_bits.delete();
    low_cfg_cycles = 0;
    cfg_falls = 0;
    phase_errs = 0;
    seen_edge = 1'b0;
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] b, input bit last);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = b;
    in_last_i  = last;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic run_load(input logic [DATA_W-1:0] bytes[$], input bit cd, input bit st,
                          input bit poke_start);
    bit exp_bits[$];
    int mism = 0;
    bit ok_status;
    foreach (bytes[i])
      for (int k = 0; k < DATA_W; k++) exp_bits.push_back(bytes[i][k]);
    for (int k = 0; k < TAIL; k++) exp_bits.push_back(1'b0);
    conf_done_i = cd;
    status_i    = st;
    clear_obs();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o && !err_o, "R10 flags cleared by start", {done_o, err_o}, 0);
    check(pwrdn_o == 1'b0, "R2 power on after start", pwrdn_o, 0);
    foreach (bytes[i]) begin
      send_byte(bytes[i], i == bytes.size() - 1);
      if (poke_start && i == 0) begin
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    while (busy_o) @(negedge clk);
    check(low_cfg_cycles == RST_CYC, "R3 configure pulse width", low_cfg_cycles, RST_CYC);
    check(cfg_falls == 1, "R9 single configure pulse", cfg_falls, 1);
    check(phase_errs == 0, "R4 clock phases and data stability", phase_errs, 0);
    check(obs_bits.size() == exp_bits.size(), "R6 clock edge count",
          obs_bits.size(), exp_bits.size());
    foreach (exp_bits[i])
      if (i < obs_bits.size() && obs_bits[i] != exp_bits[i]) mism++;
    check(mism == 0, "R4 R5 R6 bit sequence LSB first", mism, 0);
    ok_status = cd && st;
    if (ok_status) check(done_o && !err_o, "R7 success flags", {done_o, err_o}, 2);
    else           check(err_o && !done_o, "R8 error flags", {done_o, err_o}, 1);
    repeat (5) @(negedge clk);
    check((done_o == ok_status) && (err_o == !ok_status), "R10 flags sticky",
          {done_o, err_o}, ok_status ? 2 : 1);
    check(pwrdn_o == 1'b0, "R2 power stays on", pwrdn_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] q[$];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !err_o, "R1 idle flags", {busy_o, done_o, err_o}, 0);
    check(cfg_n_o && pwrdn_o, "R1 configure high, power off", {cfg_n_o, pwrdn_o}, 3);
    check(!dclk_o && !dat_o && !in_ready_o, "R1 serial lines low",
          {dclk_o, dat_o, in_ready_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwrdn_o && !busy_o, "R1 idle after reset release", {pwrdn_o, busy_o}, 2);

    q = '{8'h01, 8'h80, 8'hA5};
    run_load(q, 1'b1, 1'b1, 1'b0);
    q = '{8'h5A, 8'h00, 8'hFF};
    run_load(q, 1'b0, 1'b1, 1'b0);
    q = '{8'hC3};
    run_load(q, 1'b1, 1'b0, 1'b0);
    q = '{8'h3C, 8'h96};
    run_load(q, 1'b0, 1'b0, 1'b0);
    q = '{8'h7E, 8'h11, 8'hE8};
    run_load(q, 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule